// File: doc/BRIEF.md
# DMA Burst Address Offset Generator

This block produces the addresses for one side of a DMA channel, either the read side or the write side. A start pulse loads a start address, a data width given as a log2 code, a burst length in beats, a block size in bytes, an increment enable, a decrement select and a 13-bit inter-burst gap. The block checks that configuration once. When the configuration is valid, the block presents the address of the current beat and the byte size of the current burst, then steps forward as the transfer engine reports accepted beats and completed bursts.

Inside a burst, with incrementing enabled, each accepted beat moves the address forward by one data width. When a burst completes, the next burst begins at the old burst start, plus the burst's byte span when incrementing, plus or minus the gap. The last burst of a block is cut short when the block size does not divide evenly into bursts. No gap is added after a burst that was cut short. A one-cycle done pulse marks the end of the block.

Top module: `dma_burst_addr_gen`

## Requirements
- R1: On start, a gap whose low bits are not zero relative to the data width raises `cfg_err`. Width code 0 means 1 byte and needs no check. Code 1 means 2 bytes and bit 0 must be zero. Code 2 means 4 bytes and bits 1:0 must be zero. While `cfg_err` is high, `run` stays low.
- R2: On start, `cfg_err` is also raised if the block size is zero, if the block size is not a multiple of the data width, or if the burst length is zero.
- R3: `cfg_err` holds its value until the next start. A later start with a valid configuration clears it.
- R4: In the cycle after a valid start, `run` is high and `beat_addr` equals the start address. A start also restarts a block that is already running.
- R5: Each accepted beat that is not the last beat of its burst moves `beat_addr` up by 2^width bytes when incrementing is enabled. It leaves `beat_addr` unchanged when incrementing is disabled.
- R6: After a full-length burst completes, the next burst start is the previous burst start, plus the burst byte span when incrementing, plus the gap (decrement select low) or minus the gap (decrement select high).
- R7: `burst_bytes` is the smaller of the burst length times the width and the bytes still remaining in the block.
- R8: After a shortened final burst, `beat_addr` becomes the burst start plus the shortened span when incrementing, or the burst start when not incrementing, and no gap is applied.
- R9: `block_done` is high for exactly one cycle, in the cycle after the burst completion that empties the block. `run` is low in that same cycle.
- R10: All address arithmetic wraps modulo 2^32 in both directions.
- R11: When `beat_ack` and `burst_done` are high in the same cycle, the burst completion takes effect and the beat step is not applied as well.
- R12: While `run` is low, `beat_ack` and `burst_done` change neither `beat_addr` nor `block_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load configuration, check it and begin a block |
| beat_ack | input | 1 | The current beat was accepted |
| burst_done | input | 1 | The current burst has completed |
| cfg_base_addr | input | 32 | Start address of the block |
| cfg_wlog | input | 2 | Data width as log2 of bytes |
| cfg_beats | input | 8 | Burst length in beats |
| cfg_blk_bytes | input | 16 | Block size in bytes |
| cfg_inc | input | 1 | Incrementing addressing within bursts |
| cfg_dec | input | 1 | Subtract the gap instead of adding it |
| cfg_gap | input | 13 | Inter-burst gap in bytes |
| beat_addr | output | 32 | Address of the current beat |
| burst_bytes | output | 16 | Byte size of the current burst |
| run | output | 1 | A valid block is in progress and bursts may issue |
| block_done | output | 1 | One-cycle pulse when the block is finished |
| cfg_err | output | 1 | Latched configuration error |

## Verification
Two events can land in the same cycle: the acceptance of a burst's final beat and that burst's completion. The bench raises `beat_ack` and `burst_done` together on the last beat of every burst. The expected `beat_addr` in the next cycle is the new burst start, computed from the gap rules, and it must not carry an extra width step; this covers the precedence rule in R11. The cases include full and shortened final bursts, gaps in both directions, and address wrap.

// File: rtl/dba_pkg.sv
// Package dba_pkg: constants and helpers shared by the burst address generator.
// Assumes the width code is at most 2 bits wide (up to 8-byte beats).
package dba_pkg;
    localparam int WLOG_W = 2;

    // Mask of the address bits that must be zero for the given width code.
    function automatic logic [7:0] align_mask(input logic [WLOG_W-1:0] wlog);
        return 8'((1 << wlog) - 1);
    endfunction
endpackage

// File: rtl/dba_cfg_check.sv
// dba_cfg_check: combinational check of the configuration presented with start.
// Flags a misaligned gap, a block size that is zero or misaligned, and a zero burst length.
// Assumes OFS_W and BLK_W are both at least 8.
module dba_cfg_check
    import dba_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int BLK_W  = 16,
    parameter int BLEN_W = 8
) (
    input  logic [WLOG_W-1:0] wlog,
    input  logic [OFS_W-1:0]  gap,
    input  logic [BLK_W-1:0]  blk,
    input  logic [BLEN_W-1:0] blen,
    output logic              bad
);
    logic [OFS_W-1:0] gap_mask;
    logic [BLK_W-1:0] blk_mask;

    // Combine all the reasons a configuration is rejected.
    always_comb begin
        gap_mask = OFS_W'(align_mask(wlog));
        blk_mask = BLK_W'(align_mask(wlog));
        bad = (|(gap & gap_mask)) | (|(blk & blk_mask)) | (blk == '0) | (blen == '0);
    end
endmodule

// File: rtl/dba_block_ctr.sv
// dba_block_ctr: tracks the bytes left in the block and sizes each burst.
// A burst is the full span unless fewer bytes remain, in which case it is cut short.
// Assumes blen_q and wlog_q are already latched when run is high.
module dba_block_ctr
    import dba_pkg::*;
#(
    parameter int BLK_W  = 16,
    parameter int BLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              go,
    input  logic              burst_done,
    input  logic [BLK_W-1:0]  blk_in,
    input  logic [BLEN_W-1:0] blen_q,
    input  logic [WLOG_W-1:0] wlog_q,
    output logic              run,
    output logic [BLK_W-1:0]  burst_bytes,
    output logic              trunc,
    output logic              block_done
);
    localparam int CW = 32;

    logic [BLK_W-1:0] rem_q;
    logic [CW-1:0]    span_x;
    logic [CW-1:0]    rem_x;

    // Size the current burst as the full span, or whatever remains if that is less.
    always_comb begin
        span_x      = CW'(blen_q) << wlog_q;
        rem_x       = CW'(rem_q);
        trunc       = rem_x < span_x;
        burst_bytes = trunc ? rem_q : BLK_W'(span_x);
    end

    // Load the block size on a valid start, count it down per burst, pulse done at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q      <= '0;
            run        <= 1'b0;
            block_done <= 1'b0;
        end else begin
            block_done <= 1'b0;
            if (start) begin
                rem_q <= go ? blk_in : '0;
                run   <= go;
            end else if (run && burst_done) begin
                rem_q <= rem_q - burst_bytes;
                if (rem_q == burst_bytes) begin
                    run        <= 1'b0;
                    block_done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dba_addr_unit.sv
// dba_addr_unit: holds the current burst start and the current beat address.
// Steps by one width per beat when incrementing, and computes the next burst start when a burst ends.
// Assumes the caller has gated adv_beat and adv_burst so that they are never high together.
module dba_addr_unit
    import dba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 13,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adv_beat,
    input  logic              adv_burst,
    input  logic              inc,
    input  logic              dec,
    input  logic [WLOG_W-1:0] wlog,
    input  logic [OFS_W-1:0]  gap,
    input  logic [BLK_W-1:0]  bytes,
    input  logic              trunc,
    output logic [ADDR_W-1:0] beat_addr
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] past_burst;
    logic [ADDR_W-1:0] next_base;

    // Next burst start: the burst span when incrementing, then the gap unless the burst was cut short.
    always_comb begin
        past_burst = base_q + (inc ? ADDR_W'(bytes) : '0);
        if (trunc)
            next_base = past_burst;
        else if (dec)
            next_base = past_burst - ADDR_W'(gap);
        else
            next_base = past_burst + ADDR_W'(gap);
    end

    // Update the burst start and the beat address from load, burst-end and beat events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            beat_addr <= '0;
        end else if (load) begin
            base_q    <= addr_in;
            beat_addr <= addr_in;
        end else if (adv_burst) begin
            base_q    <= next_base;
            beat_addr <= next_base;
        end else if (adv_beat && inc) begin
            beat_addr <= beat_addr + (ADDR_W'(1) << wlog);
        end
    end
endmodule

// File: rtl/dma_burst_addr_gen.sv
// dma_burst_addr_gen: generates beat and burst addresses for one side of a DMA channel.
// Latches the configuration on start, rejects a bad configuration, then follows
// beat_ack and burst_done until the block is used up. A burst completion takes
// priority over a beat acceptance in the same cycle.
module dma_burst_addr_gen
    import dba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 13,
    parameter int BLK_W  = 16,
    parameter int BLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              beat_ack,
    input  logic              burst_done,
    input  logic [ADDR_W-1:0] cfg_base_addr,
    input  logic [WLOG_W-1:0] cfg_wlog,
    input  logic [BLEN_W-1:0] cfg_beats,
    input  logic [BLK_W-1:0]  cfg_blk_bytes,
    input  logic              cfg_inc,
    input  logic              cfg_dec,
    input  logic [OFS_W-1:0]  cfg_gap,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [BLK_W-1:0]  burst_bytes,
    output logic              run,
    output logic              block_done,
    output logic              cfg_err
);
    logic              bad;
    logic              go;
    logic              trunc;
    logic              inc_q;
    logic              dec_q;
    logic [WLOG_W-1:0] wlog_q;
    logic [BLEN_W-1:0] blen_q;
    logic [OFS_W-1:0]  gap_q;

    assign go = start && !bad;

    dba_cfg_check #(.OFS_W(OFS_W), .BLK_W(BLK_W), .BLEN_W(BLEN_W)) chk_u (
        .wlog(cfg_wlog), .gap(cfg_gap), .blk(cfg_blk_bytes), .blen(cfg_beats), .bad(bad)
    );

    // Capture the configuration and the check result on every start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q   <= 1'b0;
            dec_q   <= 1'b0;
            wlog_q  <= '0;
            blen_q  <= '0;
            gap_q   <= '0;
            cfg_err <= 1'b0;
        end else if (start) begin
            inc_q   <= cfg_inc;
            dec_q   <= cfg_dec;
            wlog_q  <= cfg_wlog;
            blen_q  <= cfg_beats;
            gap_q   <= cfg_gap;
            cfg_err <= bad;
        end
    end

    dba_block_ctr #(.BLK_W(BLK_W), .BLEN_W(BLEN_W)) ctr_u (
        .clk(clk), .rst_n(rst_n), .start(start), .go(go), .burst_done(burst_done),
        .blk_in(cfg_blk_bytes), .blen_q(blen_q), .wlog_q(wlog_q), .run(run),
        .burst_bytes(burst_bytes), .trunc(trunc), .block_done(block_done)
    );

    dba_addr_unit #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BLK_W(BLK_W)) addr_u (
        .clk(clk), .rst_n(rst_n), .load(go), .addr_in(cfg_base_addr),
        .adv_beat(run && beat_ack && !burst_done), .adv_burst(run && burst_done),
        .inc(inc_q), .dec(dec_q), .wlog(wlog_q), .gap(gap_q),
        .bytes(burst_bytes), .trunc(trunc), .beat_addr(beat_addr)
    );
endmodule

// File: rtl/dba_checker.sv
// dba_checker: properties for dma_burst_addr_gen, attached through bind.
module dba_checker
    import dba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              beat_ack,
    input logic              burst_done,
    input logic              run,
    input logic              cfg_err,
    input logic              block_done,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [BLK_W-1:0]  burst_bytes,
    input logic              inc_q,
    input logic [WLOG_W-1:0] wlog_q
);
    p_err_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !run);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> !run);

    p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && beat_ack && !burst_done && !start && inc_q)
        |=> beat_addr == $past(beat_addr) + (ADDR_W'(1) << $past(wlog_q)));

    p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && beat_ack && !burst_done && !start && !inc_q) |=> $stable(beat_addr));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(beat_addr));

    p_bytes_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> burst_bytes != '0);
endmodule

bind dma_burst_addr_gen dba_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .beat_ack(beat_ack), .burst_done(burst_done),
    .run(run), .cfg_err(cfg_err), .block_done(block_done), .beat_addr(beat_addr),
    .burst_bytes(burst_bytes), .inc_q(inc_q), .wlog_q(wlog_q)
);

// File: tb/dma_burst_addr_gen_tb_top.sv
module dma_burst_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  wlog;
        logic [7:0]  blen;
        logic [15:0] blk;
        logic        inc;
        logic        dec;
        logic [12:0] gap;
        logic        err;
        logic [3:0]  nb;
    } vec_t;

    // Fields: addr, wlog, blen, blk, inc, dec, gap, expected err, expected burst count.
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 2'd2, 8'd4, 16'd64, 1'b1, 1'b0, 13'h020, 1'b0, 4'd4},
        '{32'h0000_3000, 2'd2, 8'd1, 16'd8,  1'b1, 1'b0, 13'h002, 1'b1, 4'd0},
        '{32'h0000_2000, 2'd1, 8'd3, 16'd14, 1'b1, 1'b1, 13'h004, 1'b0, 4'd3},
        '{32'h0000_3000, 2'd1, 8'd2, 16'd4,  1'b1, 1'b0, 13'h001, 1'b1, 4'd0},
        '{32'h0000_0100, 2'd0, 8'd5, 16'd7,  1'b0, 1'b0, 13'h010, 1'b0, 4'd2},
        '{32'h0000_3000, 2'd2, 8'd1, 16'd6,  1'b1, 1'b0, 13'h000, 1'b1, 4'd0},
        '{32'hFFFF_FFF8, 2'd2, 8'd2, 16'd24, 1'b1, 1'b0, 13'h000, 1'b0, 4'd3},
        '{32'h0000_3000, 2'd0, 8'd2, 16'd0,  1'b1, 1'b0, 13'h000, 1'b1, 4'd0},
        '{32'h0000_0010, 2'd2, 8'd1, 16'd8,  1'b1, 1'b1, 13'h040, 1'b0, 4'd2},
        '{32'h0000_3000, 2'd0, 8'd0, 16'd8,  1'b1, 1'b0, 13'h000, 1'b1, 4'd0},
        '{32'h0000_0500, 2'd0, 8'd2, 16'd3,  1'b1, 1'b0, 13'h001, 1'b0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        beat_ack = 1'b0;
    logic        burst_done = 1'b0;
    logic [31:0] cfg_base_addr = '0;
    logic [1:0]  cfg_wlog = '0;
    logic [7:0]  cfg_beats = '0;
    logic [15:0] cfg_blk_bytes = '0;
    logic        cfg_inc = 1'b0;
    logic        cfg_dec = 1'b0;
    logic [12:0] cfg_gap = '0;
    logic [31:0] beat_addr;
    logic [15:0] burst_bytes;
    logic        run;
    logic        block_done;
    logic        cfg_err;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_burst_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .beat_ack(beat_ack), .burst_done(burst_done),
        .cfg_base_addr(cfg_base_addr), .cfg_wlog(cfg_wlog), .cfg_beats(cfg_beats),
        .cfg_blk_bytes(cfg_blk_bytes), .cfg_inc(cfg_inc), .cfg_dec(cfg_dec), .cfg_gap(cfg_gap),
        .beat_addr(beat_addr), .burst_bytes(burst_bytes), .run(run),
        .block_done(block_done), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_start(input vec_t v);
        @(negedge clk);
        cfg_base_addr = v.addr; cfg_wlog = v.wlog; cfg_beats = v.blen;
        cfg_blk_bytes = v.blk; cfg_inc = v.inc; cfg_dec = v.dec; cfg_gap = v.gap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] base, nxt, span, bytes, hold;
        int rem, nbt;
        drive_start(v);
        chk("R1/R2 err", 32'(cfg_err), 32'(v.err));
        chk("R1/R2 run", 32'(run), 32'(!v.err));
        if (v.err) begin
            hold = beat_addr;
            beat_ack = 1'b1; burst_done = 1'b1;
            @(negedge clk);
            beat_ack = 1'b0; burst_done = 1'b0;
            chk("R12 addr", beat_addr, hold);
            chk("R12 done", 32'(block_done), 32'd0);
            return;
        end
        chk("R4 load", beat_addr, v.addr);
        base = v.addr;
        rem  = int'(v.blk);
        span = 32'(v.blen) << v.wlog;
        for (int b = 0; b < int'(v.nb); b++) begin
            bytes = (32'(rem) < span) ? 32'(rem) : span;
            chk("R7 bytes", 32'(burst_bytes), bytes);
            nbt = int'(bytes >> v.wlog);
            for (int k = 0; k < nbt; k++) begin
                chk("R5/R10 beat", beat_addr, base + (v.inc ? (32'(k) << v.wlog) : 32'd0));
                beat_ack = 1'b1;
                burst_done = (k == nbt - 1);   // last beat: R11 overlap with completion
                @(negedge clk);
                beat_ack = 1'b0; burst_done = 1'b0;
            end
            rem -= int'(bytes);
            nxt = base + (v.inc ? bytes : 32'd0);
            if (bytes == span)
                nxt = v.dec ? nxt - 32'(v.gap) : nxt + 32'(v.gap);
            chk((bytes == span) ? "R6/R11 next" : "R8 next", beat_addr, nxt);
            chk("R9 done", 32'(block_done), 32'(rem == 0));
            base = nxt;
        end
        chk("R9 run", 32'(run), 32'd0);
        @(negedge clk);
        chk("R9 pulse", 32'(block_done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        // Reset state
        chk("R4 reset addr", beat_addr, 32'd0);
        chk("R9 reset done", 32'(block_done), 32'd0);
        chk("R3 reset err", 32'(cfg_err), 32'd0);
        chk("R7 reset bytes", 32'(burst_bytes), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R3: an error stays latched over idle cycles, then a valid start clears it
        drive_start('{32'h40, 2'd1, 8'd1, 16'd2, 1'b1, 1'b0, 13'h3, 1'b1, 4'd0});
        repeat (3) @(negedge clk);
        chk("R3 held", 32'(cfg_err), 32'd1);
        drive_start('{32'h80, 2'd1, 8'd1, 16'd2, 1'b1, 1'b0, 13'h2, 1'b0, 4'd1});
        chk("R3 cleared", 32'(cfg_err), 32'd0);

        // R4: a start while a block is running reloads the address
        beat_ack = 1'b0;
        drive_start('{32'h900, 2'd2, 8'd4, 16'd32, 1'b1, 1'b0, 13'h0, 1'b0, 4'd2});
        beat_ack = 1'b1; @(negedge clk); beat_ack = 1'b0;
        chk("R5 step", beat_addr, 32'h904);
        drive_start('{32'hA00, 2'd2, 8'd4, 16'd32, 1'b1, 1'b0, 13'h0, 1'b0, 4'd2});
        chk("R4 restart", beat_addr, 32'hA00);
        chk("R7 restart bytes", 32'(burst_bytes), 32'd16);

        // R10: a beat step wraps through zero
        drive_start('{32'hFFFF_FFFC, 2'd2, 8'd2, 16'd8, 1'b1, 1'b0, 13'h0, 1'b0, 4'd1});
        beat_ack = 1'b1; @(negedge clk); beat_ack = 1'b0;
        chk("R10 wrap", beat_addr, 32'h0);
        burst_done = 1'b1; @(negedge clk); burst_done = 1'b0;
        chk("R9 wrap done", 32'(block_done), 32'd1);

        // R12: beat_ack and burst_done while idle have no effect
        @(negedge clk);
        hold = beat_addr;
        beat_ack = 1'b1; burst_done = 1'b1;
        @(negedge clk);
        beat_ack = 1'b0; burst_done = 1'b0;
        chk("R12 idle addr", beat_addr, hold);
        chk("R12 idle done", 32'(block_done), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule